// File: doc/BRIEF.md
# Bus-Snooping CRC-CCITT Unit

This unit computes a 16-bit CRC over a byte stream with the generator x^16 + x^12 + x^5 + 1 (0x1021). It sits on a simple synchronous register bus that carries an address, write data, a write strobe and a read strobe. Software can push bytes into the CRC by writing them to a feed register. Software can also name any other bus address as a snoop target. The unit then takes every byte written to that address, or every byte read from it, and folds that byte into the CRC without any extra bus cycle.

A typical use is a DMA engine that streams a buffer into a serial transmit register. Snooping is pointed at that register. When the transfer ends, software reads the two result bytes and sends them as the checksum trailer. The unit never stalls or alters the transaction it observes. It only drives read data for its own register window.

Top module: `crc_snoop_unit`

## Requirements
- R1: After reset the CRC result, the control register and the snoop address register all read as zero.
- R2: A bus write to the feed register (offset 2 from the base address) folds the written byte into the CRC. The fold is non-reflected and takes the most significant bit first, with polynomial 0x1021. The new result is readable from the next cycle on.
- R3: A bus write to offset 0 loads bits 7:0 of the CRC and a write to offset 1 loads bits 15:8, so software sets the starting seed with these two writes.
- R4: The result reads as two bytes: bits 7:0 at offset 0 and bits 15:8 at offset 1. Read data appears on the read-data output in the same cycle as the read strobe.
- R5: When control bit 0 (enable) is 1 and control bit 1 (direction) is 0, every bus write whose address equals the snoop address register folds its write data into the CRC. The control register is at offset 3. The snoop address is stored at offset 4 (bits 7:0) and offset 5 (bits 15:8).
- R6: When control bit 0 is 1 and control bit 1 is 1, every bus read whose address equals the snoop address folds the returned data (snoop read-data input) into the CRC.
- R7: The CRC is unchanged by accesses in the following cases: snooping is disabled, the address differs from the snoop address in any bit, or the access direction does not match the selected mode.
- R8: Snooped accesses on consecutive clock cycles are each folded in, with no byte lost.
- R9: Accesses to the unit's own register window are never treated as snooped, even when the snoop address points into that window. A write to the feed register therefore folds its byte exactly once.
- R10: For any address outside its own window the unit drives zero on its read-data output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | AW | Bus address |
| bus_wdata_i | input | 8 | Bus write data |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe |
| snoop_rdata_i | input | 8 | Read data returned by the addressed target for a read in the same cycle |
| reg_rdata_o | output | 8 | Read data of the unit's own registers, zero otherwise |

## Verification
The checks assume the bus is single-access: the write and read strobes are never high together, and each strobe means one complete access in that cycle. They also assume the base address is set so that the register window does not wrap past the top of the address space. The bench drives at most one strobe per cycle, always from the falling edge. It keeps the default base address, and it places every snoop target outside the window except in the test aimed at R9.

// File: rtl/crc_snoop_pkg.sv
package crc_snoop_pkg;
  localparam int unsigned OFF_RES_LO = 0;
  localparam int unsigned OFF_RES_HI = 1;
  localparam int unsigned OFF_FEED   = 2;
  localparam int unsigned OFF_CTRL   = 3;
  localparam int unsigned OFF_SADDR  = 4;

  localparam int unsigned CTRL_EN = 0;
  localparam int unsigned CTRL_RD = 1;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_DIRECT,
    SRC_WSNOOP,
    SRC_RSNOOP
  } feed_src_e;

  typedef struct packed {
    logic       valid;
    logic [7:0] data;
  } feed_t;
endpackage

// File: rtl/crc_ccitt_step.sv
module crc_ccitt_step #(
  parameter logic [15:0] POLY = 16'h1021
) (
  input  logic [15:0] crc_i,
  input  logic [7:0]  data_i,
  output logic [15:0] crc_o
);
  logic [8:0][15:0] stage;
  logic [7:0]       fb;

  assign stage[0] = crc_i;

  for (genvar g = 0; g < 8; g++) begin : g_bit
    assign fb[g]       = stage[g][15] ^ data_i[7-g];
    assign stage[g+1]  = {stage[g][14:0], 1'b0} ^ (fb[g] ? POLY : 16'h0000);
  end

  assign crc_o = stage[8];
endmodule

// File: rtl/crc_snoop_match.sv
module crc_snoop_match
  import crc_snoop_pkg::*;
#(
  parameter int unsigned    AW        = 16,
  parameter logic [AW-1:0]  BASE_ADDR = '0,
  parameter int unsigned    NUM_REGS  = 6,
  parameter int unsigned    OFF_W     = 3
) (
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [7:0]       bus_wdata_i,
  input  logic             bus_we_i,
  input  logic             bus_re_i,
  input  logic [7:0]       snoop_rdata_i,
  input  logic [AW-1:0]    snoop_addr_i,
  input  logic             snoop_en_i,
  input  logic             snoop_rd_i,
  output logic             in_win_o,
  output logic [OFF_W-1:0] off_o,
  output feed_t            feed_o,
  output feed_src_e        src_o
);
  logic [AW-1:0] rel;
  logic          hit;

  // below-base addresses wrap to large values and fall outside
  assign rel      = bus_addr_i - BASE_ADDR;
  assign in_win_o = rel < AW'(NUM_REGS);
  assign off_o    = rel[OFF_W-1:0];
  assign hit      = snoop_en_i && !in_win_o && (bus_addr_i == snoop_addr_i);

  always_comb begin
    feed_o = '0;
    src_o  = SRC_NONE;
    if (in_win_o && bus_we_i && off_o == OFF_W'(OFF_FEED)) begin
      feed_o = '{valid: 1'b1, data: bus_wdata_i};
      src_o  = SRC_DIRECT;
    end else if (hit && !snoop_rd_i && bus_we_i) begin
      feed_o = '{valid: 1'b1, data: bus_wdata_i};
      src_o  = SRC_WSNOOP;
    end else if (hit && snoop_rd_i && bus_re_i) begin
      feed_o = '{valid: 1'b1, data: snoop_rdata_i};
      src_o  = SRC_RSNOOP;
    end
  end
endmodule

// File: rtl/crc_snoop_regs.sv
module crc_snoop_regs
  import crc_snoop_pkg::*;
#(
  parameter int unsigned   AW       = 16,
  parameter int unsigned   SA_BYTES = 2,
  parameter int unsigned   OFF_W    = 3,
  parameter logic [15:0]   POLY     = 16'h1021
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_win_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [7:0]       bus_wdata_i,
  input  logic             bus_we_i,
  input  logic             bus_re_i,
  input  feed_t            feed_i,
  output logic [15:0]      crc_o,
  output logic [AW-1:0]    snoop_addr_o,
  output logic             snoop_en_o,
  output logic             snoop_rd_o,
  output logic [7:0]       rdata_o
);
  localparam int unsigned SA_W = SA_BYTES * 8;

  logic [15:0]              crc_q, crc_nx;
  logic [1:0]               ctrl_q;
  logic [SA_BYTES-1:0][7:0] saddr_q;
  logic [SA_W-1:0]          saddr_flat;
  logic                     wr_sel, rd_sel;

  assign wr_sel = in_win_i && bus_we_i;
  assign rd_sel = in_win_i && bus_re_i;

  crc_ccitt_step #(.POLY(POLY)) step_i (
    .crc_i  (crc_q),
    .data_i (feed_i.data),
    .crc_o  (crc_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q <= '0;
    end else if (wr_sel && off_i == OFF_W'(OFF_RES_LO)) begin
      crc_q[7:0] <= bus_wdata_i;
    end else if (wr_sel && off_i == OFF_W'(OFF_RES_HI)) begin
      crc_q[15:8] <= bus_wdata_i;
    end else if (feed_i.valid) begin
      crc_q <= crc_nx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_sel && off_i == OFF_W'(OFF_CTRL)) begin
      ctrl_q <= bus_wdata_i[1:0];
    end
  end

  for (genvar g = 0; g < SA_BYTES; g++) begin : g_saddr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        saddr_q[g] <= '0;
      end else if (wr_sel && off_i == OFF_W'(OFF_SADDR + g)) begin
        saddr_q[g] <= bus_wdata_i;
      end
    end
  end

  assign saddr_flat   = saddr_q;
  assign snoop_addr_o = saddr_flat[AW-1:0];
  assign snoop_en_o   = ctrl_q[CTRL_EN];
  assign snoop_rd_o   = ctrl_q[CTRL_RD];
  assign crc_o        = crc_q;

  always_comb begin
    rdata_o = '0;
    if (rd_sel) begin
      if (off_i == OFF_W'(OFF_RES_LO))      rdata_o = crc_q[7:0];
      else if (off_i == OFF_W'(OFF_RES_HI)) rdata_o = crc_q[15:8];
      else if (off_i == OFF_W'(OFF_CTRL))   rdata_o = {6'b0, ctrl_q};
      for (int i = 0; i < SA_BYTES; i++) begin
        if (off_i == OFF_W'(OFF_SADDR + i)) rdata_o = saddr_q[i];
      end
    end
  end
endmodule

// File: rtl/crc_snoop_unit.sv
module crc_snoop_unit
  import crc_snoop_pkg::*;
#(
  parameter int unsigned   AW        = 16,
  parameter logic [AW-1:0] BASE_ADDR = AW'(16'h0380),
  parameter logic [15:0]   POLY      = 16'h1021
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [7:0]    bus_wdata_i,
  input  logic          bus_we_i,
  input  logic          bus_re_i,
  input  logic [7:0]    snoop_rdata_i,
  output logic [7:0]    reg_rdata_o
);
  localparam int unsigned SA_BYTES = (AW + 7) / 8;
  localparam int unsigned NUM_REGS = OFF_SADDR + SA_BYTES;
  localparam int unsigned OFF_W    = $clog2(NUM_REGS);

  logic             in_win;
  logic [OFF_W-1:0] off;
  feed_t            feed;
  feed_src_e        src;
  logic [AW-1:0]    snoop_addr;
  logic             snoop_en, snoop_rd;
  logic [15:0]      crc_q;
  logic             feed_vld;

  crc_snoop_match #(
    .AW(AW), .BASE_ADDR(BASE_ADDR), .NUM_REGS(NUM_REGS), .OFF_W(OFF_W)
  ) match_i (
    .bus_addr_i    (bus_addr_i),
    .bus_wdata_i   (bus_wdata_i),
    .bus_we_i      (bus_we_i),
    .bus_re_i      (bus_re_i),
    .snoop_rdata_i (snoop_rdata_i),
    .snoop_addr_i  (snoop_addr),
    .snoop_en_i    (snoop_en),
    .snoop_rd_i    (snoop_rd),
    .in_win_o      (in_win),
    .off_o         (off),
    .feed_o        (feed),
    .src_o         (src)
  );

  crc_snoop_regs #(
    .AW(AW), .SA_BYTES(SA_BYTES), .OFF_W(OFF_W), .POLY(POLY)
  ) regs_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_win_i     (in_win),
    .off_i        (off),
    .bus_wdata_i  (bus_wdata_i),
    .bus_we_i     (bus_we_i),
    .bus_re_i     (bus_re_i),
    .feed_i       (feed),
    .crc_o        (crc_q),
    .snoop_addr_o (snoop_addr),
    .snoop_en_o   (snoop_en),
    .snoop_rd_o   (snoop_rd),
    .rdata_o      (reg_rdata_o)
  );

  assign feed_vld = feed.valid && (src != SRC_NONE);
endmodule

// File: rtl/crc_snoop_chk.sv
module crc_snoop_chk #(
  parameter int unsigned   AW        = 16,
  parameter logic [AW-1:0] BASE_ADDR = '0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] bus_addr_i,
  input logic          bus_we_i,
  input logic          bus_re_i,
  input logic [7:0]    reg_rdata_o,
  input logic [15:0]   crc_q,
  input logic          feed_vld
);
  localparam int unsigned NUM_REGS = 4 + (AW + 7) / 8;

  logic [AW-1:0] rel;
  logic          in_win;
  assign rel    = bus_addr_i - BASE_ADDR;
  assign in_win = rel < AW'(NUM_REGS);

  // input assumption: one access per cycle
  a_in_single_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_i && bus_re_i));

  // R7: no access, no change
  a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_we_i && !bus_re_i) |=> $stable(crc_q));

  // R6/R5: a fold needs a bus access
  a_r6_feed_needs_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feed_vld |-> (bus_we_i || bus_re_i));

  // R9: control and snoop-address accesses never move the CRC
  a_r9_own_window_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_win && rel >= AW'(3)) |=> $stable(crc_q));

  // R9: reads in the window never fold
  a_r9_window_read_no_feed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_win && bus_re_i) |-> !feed_vld);

  // R10: foreign addresses read back zero
  a_r10_foreign_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_win |-> (reg_rdata_o == 8'h00));
endmodule

bind crc_snoop_unit crc_snoop_chk #(.AW(AW), .BASE_ADDR(BASE_ADDR)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_we_i    (bus_we_i),
  .bus_re_i    (bus_re_i),
  .reg_rdata_o (reg_rdata_o),
  .crc_q       (crc_q),
  .feed_vld    (feed_vld)
);

// File: tb/crc_snoop_unit_tb_top.sv
`timescale 1ns/1ps
module crc_snoop_unit_tb_top;
  localparam logic [15:0] BASE  = 16'h0380;
  localparam logic [15:0] A_LO  = BASE + 16'd0;
  localparam logic [15:0] A_HI  = BASE + 16'd1;
  localparam logic [15:0] A_FD  = BASE + 16'd2;
  localparam logic [15:0] A_CT  = BASE + 16'd3;
  localparam logic [15:0] A_SL  = BASE + 16'd4;
  localparam logic [15:0] A_SH  = BASE + 16'd5;
  localparam logic [15:0] TGT   = 16'h1234;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  srdata = '0;
  logic [7:0]  rdata;

  int n_chk = 0, n_fail = 0;
  logic [15:0] model;

  always #10 clk = ~clk;

  crc_snoop_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_we_i(we), .bus_re_i(re), .snoop_rdata_i(srdata), .reg_rdata_o(rdata)
  );

  function automatic logic [15:0] ref_fold(input logic [15:0] c, input logic [7:0] d);
    logic fb;
    for (int i = 0; i < 8; i++) begin
      fb = c[15] ^ d[7];
      d  = {d[6:0], 1'b0};
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] sd, output logic [7:0] d);
    @(negedge clk); addr = a; srdata = sd; re = 1'b1;
    #2 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic get_crc(output logic [15:0] c);
    logic [7:0] lo, hi;
    rd(A_LO, 8'h00, lo);
    rd(A_HI, 8'h00, hi);
    c = {hi, lo};
  endtask

  task automatic seed(input logic [15:0] s);
    wr(A_LO, s[7:0]);
    wr(A_HI, s[15:8]);
    model = s;
  endtask

  task automatic t_reset;
    logic [15:0] c; logic [7:0] d;
    get_crc(c);          chk("R1 crc", c, 16'h0000);
    rd(A_CT, 8'h00, d);  chk("R1 ctrl", {8'h0, d}, 16'h0000);
    rd(A_SL, 8'h00, d);  chk("R1 saddr lo", {8'h0, d}, 16'h0000);
    rd(A_SH, 8'h00, d);  chk("R1 saddr hi", {8'h0, d}, 16'h0000);
  endtask

  task automatic t_known;
    logic [15:0] c;
    string s = "123456789";
    seed(16'h0000);
    for (int i = 0; i < 9; i++) wr(A_FD, s[i]);
    get_crc(c); chk("R2 R4 check value seed 0", c, 16'h31C3);
    seed(16'hFFFF);
    get_crc(c); chk("R3 seed readback", c, 16'hFFFF);
    for (int i = 0; i < 9; i++) wr(A_FD, s[i]);
    get_crc(c); chk("R3 check value seed FFFF", c, 16'h29B1);
  endtask

  task automatic t_random_direct;
    logic [15:0] c; logic [7:0] b;
    for (int k = 0; k < 4; k++) begin
      seed(16'($urandom));
      for (int i = 0; i < 20; i++) begin
        b = 8'($urandom); wr(A_FD, b); model = ref_fold(model, b);
      end
      get_crc(c); chk("R2 random direct", c, model);
    end
  endtask

  task automatic t_write_snoop;
    logic [15:0] c; logic [7:0] b, d;
    wr(A_SL, TGT[7:0]); wr(A_SH, TGT[15:8]);
    wr(A_CT, 8'h01);
    seed(16'h1D0F);
    for (int i = 0; i < 32; i++) begin
      b = 8'($urandom); wr(TGT, b); model = ref_fold(model, b);
    end
    get_crc(c); chk("R5 write snoop", c, model);
    wr(TGT ^ 16'h0001, 8'h55); wr(TGT ^ 16'h8000, 8'hAA);
    rd(TGT, 8'h77, d);
    chk("R10 foreign read data", {8'h0, d}, 16'h0000);
    get_crc(c); chk("R7 mismatch and read in write mode", c, model);
  endtask

  task automatic t_read_snoop;
    logic [15:0] c; logic [7:0] b, d;
    wr(A_CT, 8'h03);
    for (int i = 0; i < 32; i++) begin
      b = 8'($urandom); rd(TGT, b, d); model = ref_fold(model, b);
    end
    get_crc(c); chk("R6 read snoop", c, model);
    wr(TGT, 8'h3C); rd(TGT ^ 16'h0100, 8'h5A, d);
    get_crc(c); chk("R7 write in read mode", c, model);
  endtask

  task automatic t_disabled;
    logic [15:0] c; logic [7:0] d;
    wr(A_CT, 8'h02);
    wr(TGT, 8'h11); rd(TGT, 8'h22, d);
    wr(A_CT, 8'h00);
    wr(TGT, 8'h33);
    get_crc(c); chk("R7 disabled", c, model);
  endtask

  task automatic t_back_to_back;
    logic [15:0] c; logic [7:0] b;
    wr(A_CT, 8'h01);
    seed(16'hBEEF);
    @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      b = 8'($urandom); addr = TGT; wdata = b; we = 1'b1;
      model = ref_fold(model, b);
      @(negedge clk);
    end
    we = 1'b0;
    get_crc(c); chk("R8 back-to-back writes", c, model);
    wr(A_CT, 8'h03);
    @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      b = 8'($urandom); addr = TGT; srdata = b; re = 1'b1;
      model = ref_fold(model, b);
      @(negedge clk);
    end
    re = 1'b0;
    get_crc(c); chk("R8 back-to-back reads", c, model);
  endtask

  task automatic t_own_window;
    logic [15:0] c;
    seed(16'h0000);
    wr(A_SL, A_FD[7:0]); wr(A_SH, A_FD[15:8]);
    wr(A_CT, 8'h01);
    wr(A_FD, 8'hC5); model = ref_fold(model, 8'hC5);
    get_crc(c); chk("R9 feed folded once", c, model);
    wr(A_SL, A_CT[7:0]);
    wr(A_CT, 8'h01);
    get_crc(c); chk("R9 ctrl write not snooped", c, model);
    wr(A_SL, A_LO[7:0]);
    wr(A_CT, 8'h03);
    get_crc(c); chk("R9 result read not snooped", c, model);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    model = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_known();
    t_random_direct();
    t_write_snoop();
    t_read_snoop();
    t_disabled();
    t_back_to_back();
    t_own_window();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule